// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer for a system I/O hub. It sits behind a small 16-bit register port that takes byte enables. A prescaler turns the core clock into a slow tick of 0.6 s, or 1 s when a parameter selects that variant. Each tick decrements a 10-bit counter. Software keeps the system alive by writing the reload register at any time. That write puts the counter back to a programmable initial value and restarts the prescaler.

The first expiry does three things:
- it sets a timeout flag;
- it can raise a one-cycle interrupt pulse;
- it reloads the counter, which keeps running.

If the counter expires again while the timeout flag is still set, the block records the event in a second-timeout flag and a boot-status flag. It also requests a system reset, unless a separate no-reboot guard bit is set. Software clears the status flags by writing 1 to them.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the block reads as follows:
  - halt bit (offset 0x08, bit 11) = 1;
  - initial-value register (0x12) = 0x0004;
  - no-reboot guard (0x0C, bit 0) = 1;
  - status 1 (0x04) = 0 and status 2 (0x06) = 0;
  - count (0x00) = 4.
- R2: While running, the count read at 0x00 bits [9:0] decreases by one every TICK_CYCLES clock cycles. TICK_CYCLES = CLKS_PER_MS × 600, or × 1000 when TICK_1S = 1.
- R3: Any write to offset 0x00, whatever its data, loads the count from the initial value on that clock edge. The same write clears the prescaler, so the next decrement comes a full TICK_CYCLES later.
- R4: The initial-value register at 0x12 holds 16 bits. Bits [9:0] are the reload value and bits [15:10] are stored and read back. A write is ignored as a whole if it would leave bits [9:0] below 4.
- R5: While the halt bit is 1 the count does not change, except through a reload write.
- R6: When a tick arrives with the count at 0, this is an expiry. On an expiry the count reloads. If the status 1 flag (0x04, bit 3) was clear, the expiry is a first expiry:
  - the block sets the flag;
  - irq_o pulses high for one cycle if tmo_irq_en_i is 1.
- R7: An expiry while status 1 bit 3 is already set is a second expiry. It sets status 2 bit 1 (second timeout) and bit 2 (boot status). It also drives rst_req_o high for exactly one cycle if the guard bit is 0.
- R8: The status bits are write-1-to-clear. Writing 0 to a status bit leaves it unchanged.
- R9: With the guard bit at 1, a second expiry still sets both status 2 bits, but rst_req_o stays low.
- R10: A write changes only the bytes whose be_i bit is 1. be_i[0] selects bits [7:0] and be_i[1] selects bits [15:8].
- R11: If status 1 bit 3 is cleared between two expiries, the later expiry counts as a first expiry and requests no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| wr_i | input | 1 | Write strobe |
| be_i | input | 2 | Byte enables for the write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| tmo_irq_en_i | input | 1 | Allows the first-expiry interrupt |
| irq_o | output | 1 | One-cycle pulse on a first expiry |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bound checker watches invariants on every cycle:
- a reset request and the interrupt are each one cycle wide;
- a reset request never appears without all three flags set, or in the cycle after the guard bit was 1;
- a halted counter holds its value;
- the stored initial value never falls below 4.

Some behaviours only the bench scenarios can show:
- the exact tick spacing and the expiry cycle;
- the reload restarting the prescaler;
- the rejection of invalid initial values under partial byte writes;
- clearing the timeout flag between expiries turning the second expiry back into a first.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned MIN_INIT = 4;

  localparam logic [7:0] OFF_RELOAD = 8'h00;
  localparam logic [7:0] OFF_STS1   = 8'h04;
  localparam logic [7:0] OFF_STS2   = 8'h06;
  localparam logic [7:0] OFF_CTL    = 8'h08;
  localparam logic [7:0] OFF_GUARD  = 8'h0C;
  localparam logic [7:0] OFF_INIT   = 8'h12;

  localparam int unsigned BIT_TMO    = 3;
  localparam int unsigned BIT_SECOND = 1;
  localparam int unsigned BIT_BOOT   = 2;
  localparam int unsigned BIT_HALT   = 11;

  function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] old_v,
                                                input logic [DW-1:0] new_v,
                                                input logic [1:0]    be);
    return {be[1] ? new_v[15:8] : old_v[15:8], be[0] ? new_v[7:0] : old_v[7:0]};
  endfunction
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int unsigned TICK_CYCLES = 600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pcnt_q <= '0;
    else if (clear_i)   pcnt_q <= '0;
    else if (run_i)     pcnt_q <= (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
  end

  assign tick_o = run_i && (pcnt_q == LAST);
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned RST_VAL = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // a reload in the same cycle as a tick wins and suppresses the expiry
  assign expire_o = tick_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)   cnt_q <= init_i;
    else if (tick_i)   cnt_q <= (cnt_q == '0) ? init_i : cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic no_reboot_i,
  input  logic irq_en_i,
  input  logic clr_tmo_i,
  input  logic clr_second_i,
  input  logic clr_boot_i,
  output logic tmo_o,
  output logic second_o,
  output logic boot_o,
  output logic irq_o,
  output logic rst_req_o
);
  logic tmo_q, second_q, boot_q, irq_q, rst_q;
  logic first_hit, second_hit;

  assign first_hit  = expire_i && !tmo_q;
  assign second_hit = expire_i && tmo_q;

  // set has priority over a same-cycle write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_q    <= 1'b0;
      second_q <= 1'b0;
      boot_q   <= 1'b0;
      irq_q    <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      if (first_hit)         tmo_q <= 1'b1;
      else if (clr_tmo_i)    tmo_q <= 1'b0;
      if (second_hit)        second_q <= 1'b1;
      else if (clr_second_i) second_q <= 1'b0;
      if (second_hit)        boot_q <= 1'b1;
      else if (clr_boot_i)   boot_q <= 1'b0;
      irq_q <= first_hit && irq_en_i;
      rst_q <= second_hit && !no_reboot_i;
    end
  end

  assign tmo_o     = tmo_q;
  assign second_o  = second_q;
  assign boot_o    = boot_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned CLKS_PER_MS = 1000,
  parameter bit          TICK_1S     = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    addr_i,
  input  logic          wr_i,
  input  logic [1:0]    be_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tmo_irq_en_i,
  output logic          irq_o,
  output logic          rst_req_o
);
  localparam int unsigned TICK_MS     = TICK_1S ? 1000 : 600;
  localparam int unsigned TICK_CYCLES = CLKS_PER_MS * TICK_MS;

  logic             halt_q, guard_q;
  logic [DW-1:0]    init_q, init_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             tick, expire, reload_we;
  logic             tmo_q, second_q, boot_q;
  logic [DW-1:0]    clr_mask;
  logic             any_be;

  assign any_be    = |be_i;
  assign reload_we = wr_i && any_be && (addr_i == OFF_RELOAD);
  assign clr_mask  = wdata_i & {{8{be_i[1]}}, {8{be_i[0]}}};
  assign init_nxt  = merge_bytes(init_q, wdata_i, be_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q  <= 1'b1;
      guard_q <= 1'b1;
      init_q  <= DW'(MIN_INIT);
    end else if (wr_i && any_be) begin
      if (addr_i == OFF_CTL && be_i[1])  halt_q  <= wdata_i[BIT_HALT];
      if (addr_i == OFF_GUARD && be_i[0]) guard_q <= wdata_i[0];
      if (addr_i == OFF_INIT && init_nxt[CNT_W-1:0] >= CNT_W'(MIN_INIT))
        init_q <= init_nxt;
    end
  end

  wdt_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk_i, .rst_ni, .run_i(!halt_q), .clear_i(reload_we), .tick_o(tick)
  );

  wdt_down_counter #(.CNT_W(CNT_W), .RST_VAL(MIN_INIT)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(reload_we),
    .init_i(init_q[CNT_W-1:0]), .cnt_o(cnt_q), .expire_o(expire)
  );

  wdt_status u_sts (
    .clk_i, .rst_ni,
    .expire_i    (expire),
    .no_reboot_i (guard_q),
    .irq_en_i    (tmo_irq_en_i),
    .clr_tmo_i   (wr_i && addr_i == OFF_STS1 && clr_mask[BIT_TMO]),
    .clr_second_i(wr_i && addr_i == OFF_STS2 && clr_mask[BIT_SECOND]),
    .clr_boot_i  (wr_i && addr_i == OFF_STS2 && clr_mask[BIT_BOOT]),
    .tmo_o       (tmo_q),
    .second_o    (second_q),
    .boot_o      (boot_q),
    .irq_o       (irq_o),
    .rst_req_o   (rst_req_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_RELOAD: rdata_o = DW'(cnt_q);
      OFF_STS1:   rdata_o[BIT_TMO] = tmo_q;
      OFF_STS2:   begin rdata_o[BIT_SECOND] = second_q; rdata_o[BIT_BOOT] = boot_q; end
      OFF_CTL:    rdata_o[BIT_HALT] = halt_q;
      OFF_GUARD:  rdata_o[0] = guard_q;
      OFF_INIT:   rdata_o = init_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             tmo_q,
  input logic             second_q,
  input logic             boot_q,
  input logic             guard_q,
  input logic             halt_q,
  input logic             reload_we,
  input logic [CNT_W-1:0] cnt_q,
  input logic [15:0]      init_q
);
  p_rst_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  p_rst_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (tmo_q && second_q && boot_q));
  p_rst_guard_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !$past(guard_q));
  p_halt_freeze_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !reload_we) |=> $stable(cnt_q));
  p_irq_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> tmo_q);
  p_irq_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_init_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q[CNT_W-1:0] >= CNT_W'(4));
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .rst_req_o(rst_req_o),
  .tmo_q(tmo_q), .second_q(second_q), .boot_q(boot_q), .guard_q(guard_q),
  .halt_q(halt_q), .reload_we(reload_we), .cnt_q(cnt_q), .init_q(init_q)
);

// File: tb/wdt_two_stage_test.sv
module wdt_two_stage_test;
  localparam int CLK_PERIOD = 10;
  localparam int T = 600;  // CLKS_PER_MS=1, 0.6 s tick

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq_en = 1'b1;
  logic        irq, rst_req;

  int checks = 0, fails = 0, rst_cnt = 0, irq_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_two_stage #(.CNT_W(10), .CLKS_PER_MS(1), .TICK_1S(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .be_i(be),
    .wdata_i(wdata), .rdata_o(rdata), .tmo_irq_en_i(irq_en),
    .irq_o(irq), .rst_req_o(rst_req)
  );

  always @(negedge clk) begin
    if (rst_req) rst_cnt++;
    if (irq) irq_cnt++;
  end

  // {wdata, be, expected readback of 0x12}
  localparam logic [33:0] VECS [8] = '{
    {16'h0010, 2'b11, 16'h0010},
    {16'h0003, 2'b11, 16'h0010},
    {16'hFC20, 2'b11, 16'hFC20},
    {16'h0000, 2'b01, 16'hFC20},
    {16'h0155, 2'b01, 16'hFC55},
    {16'h0300, 2'b10, 16'h0355},
    {16'h0001, 2'b11, 16'h0355},
    {16'h03FF, 2'b11, 16'h03FF}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [15:0] d, input logic [1:0] b = 2'b11);
    addr = a; wdata = d; be = b; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    logic [15:0] d, c0;
    int r0, i0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);

    // R1 reset state
    rd_reg(8'h08, d); chk("R1 halt", d, 16'h0800);
    rd_reg(8'h12, d); chk("R1 init", d, 16'h0004);
    rd_reg(8'h0C, d); chk("R1 guard", d, 16'h0001);
    rd_reg(8'h04, d); chk("R1 sts1", d, 16'h0000);
    rd_reg(8'h06, d); chk("R1 sts2", d, 16'h0000);
    rd_reg(8'h00, d); chk("R1 count", d, 16'h0004);

    // R5 halted after reset
    wait_neg(2000);
    rd_reg(8'h00, d); chk("R5 frozen", d, 16'h0004);

    // R4 / R10 initial-value vectors
    foreach (VECS[i]) begin
      wr_reg(8'h12, VECS[i][33:18], VECS[i][17:16]);
      rd_reg(8'h12, d);
      chk($sformatf("R4/R10 init vec %0d", i), d, VECS[i][15:0]);
    end

    // R2 R6 R7 main sequence, init 5 -> period 6 ticks
    wr_reg(8'h12, 16'h0005);
    wr_reg(8'h0C, 16'h0000);
    wr_reg(8'h08, 16'h0000);
    wr_reg(8'h00, 16'h1234);
    rd_reg(8'h00, d); chk("R3 reload", d, 16'd5);
    wait_neg(T);
    rd_reg(8'h00, d); chk("R2 one tick", d, 16'd4);
    wait_neg(2*T);
    rd_reg(8'h00, d); chk("R2 three ticks", d, 16'd2);
    wait_neg(3*T);
    chk("R6 irq pulse", 16'(irq), 16'd1);
    rd_reg(8'h04, d); chk("R6 tmo flag", d, 16'h0008);
    rd_reg(8'h00, d); chk("R6 count reload", d, 16'd5);
    chk("R7 no reset on first", 16'(rst_req), 16'd0);
    wait_neg(1);
    chk("R6 irq one cycle", 16'(irq), 16'd0);
    wait_neg(6*T - 1);
    chk("R7 reset pulse", 16'(rst_req), 16'd1);
    rd_reg(8'h06, d); chk("R7 sts2 flags", d, 16'h0006);
    chk("R7 no irq on second", 16'(irq), 16'd0);
    wait_neg(1);
    chk("R7 reset one cycle", 16'(rst_req), 16'd0);

    // R8 write-1-to-clear
    wr_reg(8'h04, 16'h0000);
    rd_reg(8'h04, d); chk("R8 write 0 keeps", d, 16'h0008);
    wr_reg(8'h04, 16'h0008);
    rd_reg(8'h04, d); chk("R8 clear tmo", d, 16'h0000);
    wr_reg(8'h06, 16'h0002);
    rd_reg(8'h06, d); chk("R8 clear second", d, 16'h0004);
    wr_reg(8'h06, 16'h0004);
    rd_reg(8'h06, d); chk("R8 clear boot", d, 16'h0000);

    // R9 guard vetoes reset, R6 irq disabled
    wr_reg(8'h0C, 16'h0001);
    irq_en = 1'b0;
    r0 = rst_cnt; i0 = irq_cnt;
    wr_reg(8'h00, 16'h0000);
    wait_neg(12*T);
    rd_reg(8'h04, d); chk("R9 tmo set", d, 16'h0008);
    rd_reg(8'h06, d); chk("R9 sts2 set", d, 16'h0006);
    chk("R9 no reset", 16'(rst_cnt - r0), 16'd0);
    chk("R6 irq masked", 16'(irq_cnt - i0), 16'd0);
    wr_reg(8'h04, 16'h0008);
    wr_reg(8'h06, 16'h0006);
    irq_en = 1'b1;

    // R11 clear between expiries
    wr_reg(8'h0C, 16'h0000);
    r0 = rst_cnt;
    wr_reg(8'h00, 16'h0000);
    wait_neg(6*T);
    rd_reg(8'h04, d); chk("R11 first expiry", d, 16'h0008);
    wr_reg(8'h04, 16'h0008);
    wait_neg(6*T - 1);
    rd_reg(8'h04, d); chk("R11 refirst", d, 16'h0008);
    rd_reg(8'h06, d); chk("R11 sts2 clear", d, 16'h0000);
    chk("R11 no reset", 16'(rst_cnt - r0), 16'd0);

    // R3 reload mid-count restarts prescaler
    wr_reg(8'h04, 16'h0008);
    wr_reg(8'h00, 16'h0000);
    wait_neg(2*T);
    rd_reg(8'h00, d); chk("R3 pre-reload", d, 16'd3);
    wr_reg(8'h00, 16'hFFFF);
    rd_reg(8'h00, d); chk("R3 reloaded", d, 16'd5);
    wait_neg(T - 1);
    rd_reg(8'h00, d); chk("R3 prescaler restarted", d, 16'd5);
    wait_neg(1);
    rd_reg(8'h00, d); chk("R3 first tick", d, 16'd4);

    // R10 halt byte enables, R5 freeze
    wr_reg(8'h08, 16'h0800, 2'b01);
    rd_reg(8'h08, d); chk("R10 low byte only", d, 16'h0000);
    wr_reg(8'h08, 16'h0800, 2'b10);
    rd_reg(8'h08, d); chk("R10 high byte", d, 16'h0800);
    rd_reg(8'h00, c0);
    wait_neg(3*T);
    rd_reg(8'h00, d); chk("R5 halted hold", d, c0);

    done = 1'b1;
    finish_run();
  end
endmodule